// File: doc/BRIEF.md
# Quadrature Zero-Crossing Imbalance Checker

This block watches the sine and cosine zero-crossing comparator bits of a rotation sensor. It brings each bit into the clock domain through two flops and treats every edge of the synchronized bit as a crossing. It times each channel's half period in clock ticks. A checker is armed only after the rotation has stayed inside a frequency window for a set run of consecutive half periods.

While armed, the block watches two things. The crossings must alternate between the channels: two crossings on one channel with none on the other between them is a frequency-imbalance fault. Also, a crossing on one channel must not follow a crossing on the other channel by less than a minimum number of ticks; a shorter gap is a phase-imbalance fault. Both fault flags stay set until reset. The armed state is reported as the valid-rotation flag.

The window limits and the phase gap are parameters in clock ticks. They are derived from the clock frequency, the 1 kHz lower limit, the 10 kHz upper limit and the required phase separation.

Top module: `quad_zc_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `rot_valid`, `fault_freq` and `fault_phase` are 0.
- R2: A crossing is either edge (0 to 1 or 1 to 0) of a channel's comparator bit after a two-flop synchronizer. A half period is the number of clock ticks between two successive crossings on the same channel.
- R3: `rot_valid` goes to 1 once ARM_HALVES (default 20) sine half periods in a row lie inside the window [HP_MIN, HP_MAX], provided no cosine half period in that run falls outside the window.
- R4: A half period shorter than HP_MIN or longer than HP_MAX on either channel restarts the run and clears `rot_valid`.
- R5: If a channel has no crossing for more than HP_MAX ticks, `rot_valid` clears and stays 0 until a fresh run completes.
- R6: While `rot_valid` is 1, two crossings on the same channel with no crossing on the other channel between them set `fault_freq`.
- R7: While `rot_valid` is 1, a crossing that follows a crossing on the other channel by fewer than PHASE_MIN ticks sets `fault_phase`. Crossings of both channels in the same tick count as a gap of 0.
- R8: Once set, `fault_freq` and `fault_phase` stay 1 until `rst`.
- R9: Neither fault flag can rise while `rot_valid` is 0. Misordered or close crossings during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sin_zc | input | 1 | Sine comparator bit, asynchronous |
| cos_zc | input | 1 | Cosine comparator bit, asynchronous |
| rot_valid | output | 1 | Rotation inside window long enough; checks armed |
| fault_freq | output | 1 | Sticky crossing-alternation fault |
| fault_phase | output | 1 | Sticky minimum-separation fault |

## Verification
On every cycle, the assertions check the reset values, that the fault flags stay set, that a fault rises only from the armed state, and that arming happens only on a sine crossing. Other behaviours depend on whole waveforms, so only the bench's scenarios can show them. These are arming after the right number of in-window half periods, disarming on a too-fast or too-slow channel or on a stall, and the alternation and separation faults. The bench drives quadrature patterns with random half periods, and directed patterns with a dropped cosine crossing or a tight phase offset.

// File: rtl/quad_zc_pkg.sv
package quad_zc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SIN  = 2'd1,
    SRC_COS  = 2'd2
  } zc_src_t;
endpackage

// File: rtl/zc_sync_edge.sv
module zc_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [2:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end
  assign edge_o = sh[2] ^ sh[1];
endmodule

// File: rtl/zc_half_period.sv
module zc_half_period #(
  parameter int HP_MIN = 40,
  parameter int HP_MAX = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic in_win,
  output logic tmo
);
  localparam int SAT = HP_MAX + 1;
  localparam int W   = $clog2(SAT + 1);

  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                  cnt <= W'(SAT);
    else if (edge_i)          cnt <= W'(1);
    else if (cnt != W'(SAT))  cnt <= cnt + W'(1);
  end

  assign in_win = (cnt >= W'(HP_MIN)) && (cnt <= W'(HP_MAX));
  assign tmo    = (cnt == W'(SAT));
endmodule

// File: rtl/zc_arm_ctrl.sv
module zc_arm_ctrl #(
  parameter int ARM_HALVES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sin_edge,
  input  logic sin_in_win,
  input  logic sin_tmo,
  input  logic cos_edge,
  input  logic cos_in_win,
  input  logic cos_tmo,
  output logic armed
);
  localparam int CW = $clog2(ARM_HALVES + 1);

  logic [CW-1:0] run_q, run_d;
  logic          breaks;

  assign breaks = sin_tmo || cos_tmo ||
                  (sin_edge && !sin_in_win) || (cos_edge && !cos_in_win);

  always_comb begin
    run_d = run_q;
    if (breaks)
      run_d = '0;
    else if (sin_edge && run_q != CW'(ARM_HALVES))
      run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      armed <= 1'b0;
    end else begin
      run_q <= run_d;
      armed <= (run_d == CW'(ARM_HALVES));
    end
  end
endmodule

// File: rtl/zc_order_check.sv
module zc_order_check
  import quad_zc_pkg::*;
#(
  parameter int PHASE_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic sin_edge,
  input  logic cos_edge,
  output logic fault_freq,
  output logic fault_phase
);
  localparam int GW = $clog2(PHASE_MIN + 1);

  zc_src_t       last_q;
  logic [GW-1:0] gap_q;
  logic          bad_order, too_close;

  always_comb begin
    bad_order = 1'b0;
    too_close = 1'b0;
    if (sin_edge && cos_edge) begin
      too_close = 1'b1;
    end else if (sin_edge) begin
      bad_order = (last_q == SRC_SIN);
      too_close = (last_q == SRC_COS) && (gap_q < GW'(PHASE_MIN));
    end else if (cos_edge) begin
      bad_order = (last_q == SRC_COS);
      too_close = (last_q == SRC_SIN) && (gap_q < GW'(PHASE_MIN));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q      <= SRC_NONE;
      gap_q       <= GW'(PHASE_MIN);
      fault_freq  <= 1'b0;
      fault_phase <= 1'b0;
    end else begin
      if (sin_edge && cos_edge) last_q <= SRC_NONE;
      else if (sin_edge)        last_q <= SRC_SIN;
      else if (cos_edge)        last_q <= SRC_COS;

      if (sin_edge || cos_edge)         gap_q <= GW'(1);
      else if (gap_q != GW'(PHASE_MIN)) gap_q <= gap_q + GW'(1);

      if (armed && bad_order) fault_freq  <= 1'b1;
      if (armed && too_close) fault_phase <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_zc_monitor.sv
module quad_zc_monitor #(
  parameter int HP_MIN     = 40,
  parameter int HP_MAX     = 400,
  parameter int PHASE_MIN  = 8,
  parameter int ARM_HALVES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sin_zc,
  input  logic cos_zc,
  output logic rot_valid,
  output logic fault_freq,
  output logic fault_phase
);
  logic [1:0] zc_in, zc_edge, zc_win, zc_tmo;
  logic       sin_edge, cos_edge;

  assign zc_in = {cos_zc, sin_zc};

  for (genvar g = 0; g < 2; g++) begin : g_ch
    zc_sync_edge u_sync (
      .clk(clk), .rst(rst), .din(zc_in[g]), .edge_o(zc_edge[g])
    );
    zc_half_period #(.HP_MIN(HP_MIN), .HP_MAX(HP_MAX)) u_hp (
      .clk(clk), .rst(rst), .edge_i(zc_edge[g]),
      .in_win(zc_win[g]), .tmo(zc_tmo[g])
    );
  end

  assign sin_edge = zc_edge[0];
  assign cos_edge = zc_edge[1];

  zc_arm_ctrl #(.ARM_HALVES(ARM_HALVES)) u_arm (
    .clk(clk), .rst(rst),
    .sin_edge(sin_edge), .sin_in_win(zc_win[0]), .sin_tmo(zc_tmo[0]),
    .cos_edge(cos_edge), .cos_in_win(zc_win[1]), .cos_tmo(zc_tmo[1]),
    .armed(rot_valid)
  );

  zc_order_check #(.PHASE_MIN(PHASE_MIN)) u_chk_order (
    .clk(clk), .rst(rst), .armed(rot_valid),
    .sin_edge(sin_edge), .cos_edge(cos_edge),
    .fault_freq(fault_freq), .fault_phase(fault_phase)
  );
endmodule

// File: rtl/quad_zc_monitor_chk.sv
module quad_zc_monitor_chk (
  input logic clk,
  input logic rst,
  input logic rot_valid,
  input logic fault_freq,
  input logic fault_phase,
  input logic sin_edge
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rot_valid && !fault_freq && !fault_phase));

  assert_arm_on_sine_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rot_valid) |-> $past(sin_edge));

  assert_freq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault_freq |=> fault_freq);

  assert_phase_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault_phase |=> fault_phase);

  assert_freq_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_freq) |-> $past(rot_valid));

  assert_phase_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_phase) |-> $past(rot_valid));
endmodule

bind quad_zc_monitor quad_zc_monitor_chk u_zc_chk (
  .clk(clk), .rst(rst), .rot_valid(rot_valid),
  .fault_freq(fault_freq), .fault_phase(fault_phase), .sin_edge(sin_edge)
);

// File: tb/sim_quad_zc_monitor.sv
module sim_quad_zc_monitor;
  localparam int HP_MIN = 40, HP_MAX = 400, PHASE_MIN = 8, ARM = 20;

  logic clk = 0, rst = 1, sin_zc = 0, cos_zc = 0;
  logic rot_valid, fault_freq, fault_phase;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_zc_monitor #(.HP_MIN(HP_MIN), .HP_MAX(HP_MAX),
                    .PHASE_MIN(PHASE_MIN), .ARM_HALVES(ARM)) u0 (
    .clk(clk), .rst(rst), .sin_zc(sin_zc), .cos_zc(cos_zc),
    .rot_valid(rot_valid), .fault_freq(fault_freq), .fault_phase(fault_phase)
  );

  function automatic bit exp_valid(int h);
    return (h >= HP_MIN) && (h <= HP_MAX);
  endfunction

  function automatic bit exp_phase(int h, int p);
    return exp_valid(h) && ((p < PHASE_MIN) || (h - p < PHASE_MIN));
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; sin_zc = 0; cos_zc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // sine toggles every h ticks; cosine toggles p ticks after each sine toggle;
  // the cosine toggle numbered skip (1-based) is dropped
  task automatic drive(int h, int p, int nhalf, int skip);
    int k = 0;
    for (int t = 1; t <= nhalf * h; t++) begin
      @(negedge clk);
      if (t % h == 0) sin_zc = ~sin_zc;
      if (t % h == p) begin
        k++;
        if (k != skip) cos_zc = ~cos_zc;
      end
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", rot_valid, 1'b0);
    chk("R1 ffreq in reset", fault_freq, 1'b0);
    chk("R1 fphase in reset", fault_phase, 1'b0);
    do_reset();
    @(negedge clk);
    chk("R1 valid after reset", rot_valid, 1'b0);

    // R2 R3: random in-window quadrature arms, no faults
    for (int i = 0; i < 6; i++) begin
      int h = 60 + int'($urandom_range(0, 240));
      do_reset();
      drive(h, h / 2, 10, 0);
      chk("R3 not armed early", rot_valid, 1'b0);
      drive(h, h / 2, ARM + 6, 0);
      chk("R3 armed", rot_valid, exp_valid(h));
      chk("R6 no freq fault", fault_freq, 1'b0);
      chk("R7 no phase fault", fault_phase, exp_phase(h, h / 2));
    end

    // R4: too-fast rotation never arms, then arm and break with fast halves
    do_reset();
    drive(30, 15, 60, 0);
    chk("R4 fast never arms", rot_valid, exp_valid(30));
    do_reset();
    drive(100, 50, ARM + 4, 0);
    chk("R4 armed first", rot_valid, 1'b1);
    drive(30, 15, 4, 0);
    chk("R4 fast half disarms", rot_valid, 1'b0);

    // R5: stall clears valid
    do_reset();
    drive(100, 50, ARM + 4, 0);
    chk("R5 armed before stall", rot_valid, 1'b1);
    repeat (HP_MAX + 20) @(negedge clk);
    chk("R5 stall clears valid", rot_valid, 1'b0);
    chk("R5 stall no fault", fault_freq, 1'b0);

    // R6 R8: dropped cosine crossing while armed
    do_reset();
    drive(100, 50, ARM + 4, 0);
    drive(100, 50, 4, 2);
    repeat (10) @(negedge clk);
    chk("R6 freq fault", fault_freq, 1'b1);
    chk("R6 phase clean", fault_phase, 1'b0);
    drive(100, 50, 30, 0);
    chk("R8 freq fault sticky", fault_freq, 1'b1);
    do_reset();
    @(negedge clk);
    chk("R8 cleared by reset", fault_freq, 1'b0);

    // R7: tight offset while armed
    do_reset();
    drive(120, 3, ARM + 6, 0);
    chk("R7 phase fault", fault_phase, exp_phase(120, 3));
    chk("R7 freq clean", fault_freq, 1'b0);

    // R9: misorder and tight offset while not armed (too fast) are ignored
    do_reset();
    drive(30, 2, 40, 5);
    chk("R9 no freq fault unarmed", fault_freq, 1'b0);
    chk("R9 no phase fault unarmed", fault_phase, 1'b0);
    chk("R9 still unarmed", rot_valid, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule